// File: doc/BRIEF.md
# Zoned-to-Packed Decimal Packer

This block turns a zoned decimal field, which carries one digit per byte, into packed decimal with two digits per byte. Zoned bytes arrive one per clock on a byte-wide source port whenever `src_valid_i` is high. The field length is a 4-bit code sampled together with the first byte of each field. Packed bytes leave on a byte-wide sink port, each one registered in the clock after the zoned byte that completes it.

Each zoned byte holds a zone nibble in bits 7:4 and a digit nibble in bits 3:0. All zones are discarded except the zone of the final byte, which carries the sign. That zone becomes the low nibble of the last packed byte, beneath the final digit. When the digit count is even, the first packed byte gets a zero high nibble so that the digits and the sign together fill whole bytes. A digit nibble above 1001 raises an error flag at the end of the field. The packed bytes are still produced, with the raw nibble in place.

Top module: `zp_packer`

## Requirements
- R1: After reset is released, `snk_valid_o`, `done_o` and `err_o` are all low until a zoned byte is accepted.
- R2: A byte is accepted on every rising clock edge while `src_valid_i` is high. `len_i` is sampled only with the first byte of a field and gives a field of `len_i`+1 bytes (code 0 is one byte, code 15 is sixteen). `len_i` is ignored during the rest of the field. The first byte of a new field may follow the last byte of the previous field on the very next clock.
- R3: Digits are packed in order, two per byte, with the earlier digit in bits 7:4. A field of N digits yields floor(N/2)+1 packed bytes. Each packed byte is valid in the cycle after the edge that accepted the zoned byte supplying its bits 3:0.
- R4: When N is even, the first packed byte is 0000 followed by the first digit, and it is valid in the cycle after the first zoned byte is accepted.
- R5: The last packed byte holds the last digit in bits 7:4 and, in bits 3:0, the zone nibble of the last zoned byte copied unchanged. Plus is 1100, minus is 1101 and unsigned is 1111. The zones of all other bytes have no effect on any output.
- R6: `done_o` is high exactly in the cycle that carries the last packed byte of a field.
- R7: `err_o` is high together with `done_o` when any digit nibble in the field exceeds 1001. The packed bytes are emitted regardless, with the raw nibble values. At all other times `err_o` is low.
- R8: A cycle with `src_valid_i` low neither advances the field nor produces output. `snk_valid_o` is low in the following cycle, and `src_data_i` and `len_i` are ignored during that cycle.
- R9: The zoned minus-123 field F1 F2 D3 (length code 2) packs to the two bytes 12 and 3D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_valid_i | input | 1 | Zoned byte present this cycle |
| src_data_i | input | 8 | Zoned byte: zone in bits 7:4, digit in bits 3:0 |
| len_i | input | LEN_W (4) | Length code (bytes minus one), sampled with the first byte of a field |
| snk_valid_o | output | 1 | Packed byte present |
| snk_data_o | output | 8 | Packed byte |
| done_o | output | 1 | Last packed byte of the field |
| err_o | output | 1 | Field held a digit nibble above 1001 (valid with done_o) |

## Verification
Every output of the block is due exactly one clock after the rising edge that accepts the zoned byte producing it. That covers a packed byte, the leading-pad byte, the sign byte and the done and error flags. Idle cycles produce nothing one clock later. The bench drives on the falling edge and records, with each stimulus, what the outputs must be after the next rising edge. It compares all four outputs on the following falling edge, every cycle. The expected bytes come from a nibble string that the bench builds per field from its digits, its pad and its sign. The random runs vary length, sign, zone garbage, digit values and idle gaps.

// File: rtl/zp_pkg.sv
package zp_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned BYTE_W = 2 * NIB_W;

  typedef logic [NIB_W-1:0] nib_t;

  typedef struct packed {
    nib_t zone;
    nib_t digit;
  } zoned_t;

  function automatic logic digit_bad(nib_t d);
    return d > nib_t'(9);
  endfunction
endpackage

// File: rtl/zp_seq_ctrl.sv
// Tracks bytes remaining in the field and classifies each accepted byte.
module zp_seq_ctrl #(
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             first_o,
  output logic             last_o,
  output logic             low_o,
  output logic             high_o
);
  logic             busy_q;
  logic [LEN_W-1:0] rem_q;
  logic [LEN_W-1:0] cur_rem;

  assign cur_rem = busy_q ? rem_q : len_i;
  assign first_o = valid_i && !busy_q;
  assign last_o  = valid_i && (cur_rem == '0);
  // bytes-after-this odd: digit fills a low nibble
  assign low_o   = valid_i && cur_rem[0];
  assign high_o  = valid_i && (cur_rem != '0) && !cur_rem[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
    end else if (valid_i) begin
      busy_q <= (cur_rem != '0);
      rem_q  <= cur_rem - LEN_W'(1);
    end
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(busy_q) && $stable(rem_q)) else $error("idle advanced"); // R8
  AST_LAST_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !busy_q) else $error("field not closed"); // R2
endmodule

// File: rtl/zp_pair_reg.sv
// Holds the pending high digit and registers each completed packed byte.
module zp_pair_reg
  import zp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              first_i,
  input  logic              last_i,
  input  logic              low_i,
  input  logic              high_i,
  input  zoned_t            byte_i,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_data_o,
  output logic              done_o
);
  nib_t hi_q;
  nib_t hi_src;

  // a field opening on a low nibble is padded with zero
  assign hi_src = first_i ? nib_t'(0) : hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q        <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      done_o      <= 1'b0;
    end else begin
      if (high_i) hi_q <= byte_i.digit;
      out_valid_o <= low_i || last_i;
      done_o      <= last_i;
      if (last_i)     out_data_o <= {byte_i.digit, byte_i.zone};
      else if (low_i) out_data_o <= {hi_src, byte_i.digit};
    end
  end

  AST_HIGH_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    high_i |=> !out_valid_o) else $error("output on high digit"); // R3
endmodule

// File: rtl/zp_err_track.sv
module zp_err_track
  import zp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic last_i,
  input  nib_t digit_i,
  output logic err_o
);
  logic acc_q;
  logic bad;

  assign bad = valid_i && digit_bad(digit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= 1'b0;
      err_o <= 1'b0;
    end else begin
      err_o <= last_i && (acc_q || bad);
      if (last_i)   acc_q <= 1'b0;
      else if (bad) acc_q <= 1'b1;
    end
  end

  AST_BAD_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_i && bad) |=> err_o) else $error("bad last digit missed"); // R7
endmodule

// File: rtl/zp_packer.sv
module zp_packer
  import zp_pkg::*;
#(
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_valid_i,
  input  logic [7:0]       src_data_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             snk_valid_o,
  output logic [7:0]       snk_data_o,
  output logic             done_o,
  output logic             err_o
);
  logic   first, last, low, high;
  zoned_t in_byte;

  assign in_byte = zoned_t'(src_data_i);

  zp_seq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (src_valid_i),
    .len_i   (len_i),
    .first_o (first),
    .last_o  (last),
    .low_o   (low),
    .high_o  (high)
  );

  zp_pair_reg u_pair (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .first_i     (first),
    .last_i      (last),
    .low_i       (low),
    .high_i      (high),
    .byte_i      (in_byte),
    .out_valid_o (snk_valid_o),
    .out_data_o  (snk_data_o),
    .done_o      (done_o)
  );

  zp_err_track u_err (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (src_valid_i),
    .last_i  (last),
    .digit_i (in_byte.digit),
    .err_o   (err_o)
  );

  AST_DONE_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> snk_valid_o) else $error("done without data"); // R6
  AST_ERR_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o) else $error("err outside done"); // R7
  AST_IDLE_NO_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_valid_i |=> !snk_valid_o) else $error("output after idle"); // R8
  AST_SIGN_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> snk_data_o[3:0] == $past(src_data_i[7:4])) else $error("sign lost"); // R5
  AST_LAST_DIGIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> snk_data_o[7:4] == $past(src_data_i[3:0])) else $error("last digit lost"); // R5
  AST_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first && len_i[0]) |=> snk_valid_o && snk_data_o[7:4] == 4'h0) else $error("pad missing"); // R4
endmodule

// File: tb/zp_packer_tb.sv
module zp_packer_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       src_valid_i = 1'b0;
  logic [7:0] src_data_i = '0;
  logic [3:0] len_i = '0;
  logic       snk_valid_o, done_o, err_o;
  logic [7:0] snk_data_o;

  int vectors = 0;
  int misses  = 0;
  bit reported = 0;

  logic       exp_v = 0, exp_done = 0, exp_err = 0;
  logic [7:0] exp_d = '0;
  string      exp_tag = "R1";

  int f_dig [16];
  int f_zone[16];

  always #5 clk_i = ~clk_i;

  zp_packer u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_valid_i (src_valid_i),
    .src_data_i  (src_data_i),
    .len_i       (len_i),
    .snk_valid_o (snk_valid_o),
    .snk_data_o  (snk_data_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    end
  endtask

  task automatic compare();
    vectors++;
    if (snk_valid_o !== exp_v || (exp_v && snk_data_o !== exp_d) ||
        done_o !== exp_done || err_o !== exp_err) begin
      misses++;
      $display("FAIL %s: v/data/done/err got %0b/%02h/%0b/%0b exp %0b/%02h/%0b/%0b",
               exp_tag, snk_valid_o, snk_data_o, done_o, err_o,
               exp_v, exp_d, exp_done, exp_err);
    end
  endtask

  // check outputs due from the previous stimulus, then apply the next one
  task automatic step(input logic v, input logic [7:0] b, input logic [3:0] l,
                      input logic ev, input logic [7:0] ed, input logic edn,
                      input logic eerr, input string tag);
    @(negedge clk_i);
    compare();
    src_valid_i = v; src_data_i = b; len_i = l;
    exp_v = ev; exp_d = ed; exp_done = edn; exp_err = eerr; exp_tag = tag;
  endtask

  task automatic idle(input string tag);
    step(1'b0, 8'($urandom), 4'($urandom), 1'b0, 8'h00, 1'b0, 1'b0, tag);
  endtask

  // model: build the packed nibble string, then release byte j once its low nibble is in
  task automatic run_field(input int n, input int stall_pct, input string tag);
    int  nib[34];
    int  pad, pos;
    bit  bad;
    pad = (n % 2 == 0) ? 1 : 0;
    pos = 0;
    bad = 0;
    if (pad == 1) begin nib[pos] = 0; pos++; end
    for (int i = 0; i < n; i++) begin
      nib[pos] = f_dig[i]; pos++;
      if (f_dig[i] > 9) bad = 1;
    end
    nib[pos] = f_zone[n-1];
    for (int idx = 0; idx < n; idx++) begin
      bit         emit, last;
      int         j;
      logic [7:0] ed;
      logic [3:0] l;
      while (int'($urandom_range(99)) < stall_pct) idle("R8");
      last = (idx == n - 1);
      emit = (((idx + pad) % 2) == 1) || last;
      j    = (idx + pad) / 2;
      ed   = {4'(nib[2*j]), 4'(nib[2*j+1])};
      l    = (idx == 0) ? 4'(n - 1) : 4'($urandom); // later codes must be ignored (R2)
      step(1'b1, {4'(f_zone[idx]), 4'(f_dig[idx])}, l, emit, emit ? ed : 8'h00,
           last, last && bad, tag);
    end
  endtask

  task automatic fill_random(input int n, input int bad_pct);
    int signs[3] = '{12, 13, 15};
    for (int i = 0; i < n; i++) begin
      f_dig[i]  = (int'($urandom_range(99)) < bad_pct) ? int'($urandom_range(15, 10))
                                                        : int'($urandom_range(9));
      f_zone[i] = int'($urandom_range(15)); // garbage zones are discarded (R5)
    end
    f_zone[n-1] = signs[$urandom_range(2)];
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    misses++;
    $display("FAIL watchdog: run did not finish, got hang exp completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: quiet after reset
    exp_tag = "R1";
    idle("R1");
    idle("R1");

    // R9: minus 123
    f_dig[0] = 1; f_dig[1] = 2; f_dig[2] = 3;
    f_zone[0] = 15; f_zone[1] = 15; f_zone[2] = 13;
    run_field(3, 0, "R9");
    idle("R9");
    @(negedge clk_i);
    vectors++;
    if (snk_valid_o !== 1'b0) begin
      misses++;
      $display("FAIL R9: trailing valid got %0b exp 0", snk_valid_o);
    end

    // R2: single-byte field, code 0, unsigned
    f_dig[0] = 7; f_zone[0] = 15;
    run_field(1, 0, "R2");
    // R2: longest field, back to back with the next
    fill_random(16, 0);
    run_field(16, 0, "R2");
    // R4: even count pads with zero
    fill_random(2, 0);
    run_field(2, 0, "R4");
    fill_random(4, 0);
    run_field(4, 30, "R4");
    // R5: plus sign with garbage zones elsewhere
    fill_random(5, 0);
    f_zone[4] = 12;
    run_field(5, 0, "R5");
    // R7: bad digit in the middle, then a clean field clears it
    fill_random(6, 0);
    f_dig[2] = 12;
    run_field(6, 0, "R7");
    fill_random(3, 0);
    run_field(3, 0, "R7");
    // R7: bad last digit
    fill_random(3, 0);
    f_dig[2] = 15;
    run_field(3, 20, "R7");
    // R8: long gap mid-field
    fill_random(7, 0);
    run_field(7, 60, "R8");

    // R3, R5, R6: random lengths, signs, digits, gaps
    for (int k = 0; k < 300; k++) begin
      int n;
      n = int'($urandom_range(16, 1));
      fill_random(n, 5);
      run_field(n, (k % 3) * 20, "R3/R5/R6");
    end
    idle("R6");
    idle("R8");
    @(negedge clk_i);
    compare();
    summary();
    $finish;
  end
endmodule